// File: doc/BRIEF.md
# Sampling Array Acquisition Sequencer

This block controls a four-channel switched-capacitor sampling array of 256 cells per channel. It runs the array through three phases, one after another. First it samples: while the trigger input is high, a circular pointer moves through the cells and a one-hot write strobe selects the cell that takes the current sample. Next it converts: when the trigger falls, the pointer freezes, the frozen position is kept as the stop address, and a conversion start pulse is issued. Last it reads out: once conversion is complete, a read enable stays high until readout reports that it is finished.

After readout the sequencer waits. A new sampling phase begins only when the trigger is high again, and that phase starts from cell 0. The stop address lets downstream logic find the oldest sample in the circular record. The analog sampling and the conversion hardware are outside this block.

Top module: `sca_acq_seq`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and in the first cycle after it, the block is in the sampling phase with the pointer at cell 0. In that state `stop_addr` is 0, `conv_start` is 0 and `rd_en` is 0.
- R2: In the sampling phase, when `trig` is high, `wr_en` has exactly one bit set: bit k, where k is the current pointer. When `trig` is low, `wr_en` is all zero.
- R3: Each rising clock edge in the sampling phase with `trig` high moves the pointer up by one. After cell 255 the pointer goes back to cell 0.
- R4: If `trig` is low in the sampling phase, and at least one sampling cycle has happened since that phase began, the block enters the convert phase at the next edge. At that edge `stop_addr` takes the frozen pointer value, which is the number of sampling cycles modulo 256.
- R5: `conv_start` is high for exactly one cycle. That cycle is the first cycle of the convert phase.
- R6: In the convert phase, `conv_done` high moves the block to the read phase at the next edge. `rd_en` is high for the whole read phase. `rd_done` has no effect during the convert phase.
- R7: In the read phase, `rd_done` high moves the block to a wait phase at the next edge, and `rd_en` falls. `conv_done` has no effect during the read phase.
- R8: In the convert, read and wait phases, `wr_en` is all zero whatever the value of `trig`. In the wait phase, `trig` high starts a new sampling phase at the next edge, with the pointer at cell 0.
- R9: In a sampling phase where no sampling cycle has happened yet, `trig` low holds the pointer and does not start a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig | input | 1 | Trigger level; high means sample, low means hold |
| conv_done | input | 1 | Conversion finished |
| rd_done | input | 1 | Readout finished |
| wr_en | output | 256 | One-hot cell write strobes |
| stop_addr | output | 8 | Pointer value latched when the trigger falls |
| conv_start | output | 1 | One-cycle conversion start pulse |
| rd_en | output | 1 | High during the read phase |

## Verification
`wr_en` is combinational from `trig` and the registered pointer and phase. Its value is therefore due in the same cycle that `trig` is applied. `stop_addr`, `conv_start` and `rd_en` each sit behind one register, so they change in the cycle after the edge at which their cause was sampled. The bench drives inputs at the falling clock edge and samples one nanosecond later. This means a combinational result is checked in the cycle it is driven, and a registered result is checked one driven cycle after its cause. The expected values in the vector table and in the directed tests are laid out to follow this one-cycle offset.

// File: rtl/sca_seq_pkg.sv
`timescale 1ns/1ps
package sca_seq_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_CONV  = 2'd1,
    MODE_READ  = 2'd2,
    MODE_REARM = 2'd3
  } seq_mode_t;

  // circular successor of a cell index
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned cells);
    return (idx >= cells - 1) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/sca_wr_ring.sv
`timescale 1ns/1ps
module sca_wr_ring #(
  parameter int CELLS = 256
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      advance,
  input  logic                      restart,
  input  logic                      gate,
  output logic [$clog2(CELLS)-1:0]  ptr,
  output logic [CELLS-1:0]          wr_en
);
  import sca_seq_pkg::*;
  localparam int PW = $clog2(CELLS);

  logic [PW-1:0] ptr_nxt;
  assign ptr_nxt = PW'(ring_next(int'(ptr), CELLS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (restart) ptr <= '0;
    else if (advance) ptr <= ptr_nxt;
  end

  for (genvar g = 0; g < CELLS; g++) begin : g_strobe
    assign wr_en[g] = gate && (ptr == PW'(g));
  end
endmodule

// File: rtl/sca_mode_fsm.sv
`timescale 1ns/1ps
module sca_mode_fsm #(
  parameter int CELLS = 256
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           trig,
  input  logic                           conv_done,
  input  logic                           rd_done,
  input  logic [$clog2(CELLS)-1:0]       ptr,
  output sca_seq_pkg::seq_mode_t         mode,
  output logic [$clog2(CELLS)-1:0]       stop_addr,
  output logic                           conv_start,
  output logic                           rd_en,
  output logic                           sampling,
  output logic                           stop_evt,
  output logic                           rearm_evt
);
  import sca_seq_pkg::*;

  logic armed;
  logic conv_fin;
  logic read_fin;

  assign sampling  = (mode == MODE_WRITE) && trig;
  assign stop_evt  = (mode == MODE_WRITE) && armed && !trig;
  assign rearm_evt = (mode == MODE_REARM) && trig;
  assign conv_fin  = (mode == MODE_CONV) && conv_done;
  assign read_fin  = (mode == MODE_READ) && rd_done;
  assign rd_en     = (mode == MODE_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= MODE_WRITE;
      armed      <= 1'b0;
      stop_addr  <= '0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= stop_evt;
      if (stop_evt) begin
        mode      <= MODE_CONV;
        armed     <= 1'b0;
        stop_addr <= ptr;
      end else if (sampling) begin
        armed <= 1'b1;
      end else if (conv_fin) begin
        mode <= MODE_READ;
      end else if (read_fin) begin
        mode <= MODE_REARM;
      end else if (rearm_evt) begin
        mode <= MODE_WRITE;
      end
    end
  end
endmodule

// File: rtl/sca_acq_seq.sv
`timescale 1ns/1ps
module sca_acq_seq #(
  parameter int CELLS = 256
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      trig,
  input  logic                      conv_done,
  input  logic                      rd_done,
  output logic [CELLS-1:0]          wr_en,
  output logic [$clog2(CELLS)-1:0]  stop_addr,
  output logic                      conv_start,
  output logic                      rd_en
);
  import sca_seq_pkg::*;
  localparam int PW = $clog2(CELLS);

  seq_mode_t     mode;
  logic [PW-1:0] ptr;
  logic          sampling;
  logic          stop_evt;
  logic          rearm_evt;

  sca_mode_fsm #(.CELLS(CELLS)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig       (trig),
    .conv_done  (conv_done),
    .rd_done    (rd_done),
    .ptr        (ptr),
    .mode       (mode),
    .stop_addr  (stop_addr),
    .conv_start (conv_start),
    .rd_en      (rd_en),
    .sampling   (sampling),
    .stop_evt   (stop_evt),
    .rearm_evt  (rearm_evt)
  );

  sca_wr_ring #(.CELLS(CELLS)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (sampling),
    .restart (rearm_evt),
    .gate    (sampling),
    .ptr     (ptr),
    .wr_en   (wr_en)
  );
endmodule

// File: rtl/sca_acq_seq_chk.sv
`timescale 1ns/1ps
module sca_acq_seq_chk #(
  parameter int CELLS = 256
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           trig,
  input logic                           conv_done,
  input logic                           rd_done,
  input sca_seq_pkg::seq_mode_t         mode,
  input logic [$clog2(CELLS)-1:0]       ptr,
  input logic                           stop_evt,
  input logic [CELLS-1:0]               wr_en,
  input logic [$clog2(CELLS)-1:0]       stop_addr,
  input logic                           conv_start,
  input logic                           rd_en
);
  import sca_seq_pkg::*;
  localparam int PW = $clog2(CELLS);

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(wr_en)); // R2
  AST_WR_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n) !trig |-> wr_en == '0); // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_WRITE && trig) |=> ptr == (($past(ptr) == PW'(CELLS-1)) ? '0 : $past(ptr) + 1'b1)); // R3
  AST_STOP_LATCH: assert property (@(posedge clk) disable iff (!rst_n) stop_evt |=> stop_addr == $past(ptr)); // R4
  AST_CS_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n) stop_evt |=> conv_start); // R5
  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) conv_start |=> !conv_start); // R5
  AST_RD_ENTER: assert property (@(posedge clk) disable iff (!rst_n) (mode == MODE_CONV && conv_done) |=> rd_en); // R6
  AST_RD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_READ && rd_done) |=> (!rd_en && mode == MODE_REARM)); // R7
  AST_IDLE_NO_WR: assert property (@(posedge clk) disable iff (!rst_n) (mode != MODE_WRITE) |-> wr_en == '0); // R8
  AST_REARM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_REARM && trig) |=> (mode == MODE_WRITE && ptr == '0)); // R8
endmodule

bind sca_acq_seq sca_acq_seq_chk #(.CELLS(CELLS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trig       (trig),
  .conv_done  (conv_done),
  .rd_done    (rd_done),
  .mode       (mode),
  .ptr        (ptr),
  .stop_evt   (stop_evt),
  .wr_en      (wr_en),
  .stop_addr  (stop_addr),
  .conv_start (conv_start),
  .rd_en      (rd_en)
);

// File: tb/sca_acq_seq_test.sv
`timescale 1ns/1ps
module sca_acq_seq_test;
  localparam int CELLS = 256;
  localparam int NV = 14;
  // columns: trig, conv_done, rd_done, expected write index (-1 none), conv_start, rd_en, stop_addr
  localparam int VEC [NV][7] = '{
    '{1, 0, 0,  0, 0, 0, 0},  // R2 cell 0
    '{1, 0, 0,  1, 0, 0, 0},  // R3 advance
    '{1, 0, 0,  2, 0, 0, 0},  // R3 advance
    '{0, 0, 0, -1, 0, 0, 0},  // R4 trigger drop, strobes off
    '{0, 0, 0, -1, 1, 0, 3},  // R5 start pulse, R4 stop address
    '{1, 0, 0, -1, 0, 0, 3},  // R8 trig ignored in convert
    '{0, 1, 0, -1, 0, 0, 3},  // R6 conversion finishes
    '{1, 0, 0, -1, 0, 1, 3},  // R6 read phase
    '{0, 1, 0, -1, 0, 1, 3},  // R7 conv_done ignored in read
    '{0, 0, 1, -1, 0, 1, 3},  // R7 readout finishes
    '{0, 0, 0, -1, 0, 0, 3},  // R7 wait phase
    '{1, 0, 0, -1, 0, 0, 3},  // R8 rearm, no strobes yet
    '{1, 0, 0,  0, 0, 0, 3},  // R8 new phase from cell 0
    '{1, 0, 0,  1, 0, 0, 3}   // R3 advance again
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic conv_done = 1'b0;
  logic rd_done = 1'b0;
  logic [CELLS-1:0] wr_en;
  logic [7:0] stop_addr;
  logic conv_start;
  logic rd_en;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sca_acq_seq #(.CELLS(CELLS)) uut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .conv_done(conv_done), .rd_done(rd_done),
    .wr_en(wr_en), .stop_addr(stop_addr), .conv_start(conv_start), .rd_en(rd_en)
  );

  function automatic logic [CELLS-1:0] strobe_of(input int idx);
    return (idx < 0) ? '0 : ({{(CELLS-1){1'b0}}, 1'b1} << idx);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_wr(input string req, input int idx);
    n_run++;
    if (wr_en !== strobe_of(idx)) begin
      n_fail++;
      $display("FAIL %s: wr_en=%h expected %h", req, wr_en, strobe_of(idx));
    end
  endtask

  task automatic cyc(input logic t, input logic cd, input logic rd);
    @(negedge clk);
    trig = t; conv_done = cd; rd_done = rd;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; trig = 1'b0; conv_done = 1'b0; rd_done = 1'b0;
    #1;
    chk_wr("R1 wr_en in reset", -1);
    chk("R1 stop_addr in reset", int'(stop_addr), 0);
    chk("R1 conv_start in reset", int'(conv_start), 0);
    chk("R1 rd_en in reset", int'(rd_en), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // table walk: one full sample/convert/read/rearm cycle
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][0][0], VEC[i][1][0], VEC[i][2][0]);
      chk_wr($sformatf("vec%0d wr_en", i), VEC[i][3]);
      chk($sformatf("vec%0d conv_start", i), int'(conv_start), VEC[i][4]);
      chk($sformatf("vec%0d rd_en", i), int'(rd_en), VEC[i][5]);
      chk($sformatf("vec%0d stop_addr", i), int'(stop_addr), VEC[i][6]);
    end

    // R3 wrap: 300 sampling cycles, stop address 300 mod 256 = 44
    do_reset();
    for (int i = 0; i < 300; i++) begin
      cyc(1'b1, 1'b0, 1'b0);
      chk_wr("R3 wrap pointer", i % CELLS);
    end
    cyc(1'b0, 1'b0, 1'b0);
    chk_wr("R4 strobes off on drop", -1);
    chk("R5 no pulse before edge", int'(conv_start), 0);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R4 stop address after wrap", int'(stop_addr), 44);
    chk("R5 pulse after stop", int'(conv_start), 1);
    // R6: rd_done ignored while converting
    cyc(1'b0, 1'b0, 1'b1);
    chk("R5 pulse one cycle", int'(conv_start), 0);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R6 rd_done ignored in convert", int'(rd_en), 0);
    cyc(1'b0, 1'b1, 1'b0);
    chk("R6 still converting", int'(rd_en), 0);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R6 read entered", int'(rd_en), 1);

    // R1: reset in the middle of the read phase
    do_reset();
    cyc(1'b0, 1'b0, 1'b0);
    chk("R1 rd_en after reset", int'(rd_en), 0);
    chk("R1 stop_addr after reset", int'(stop_addr), 0);

    // R9: trig low with no sampling yet holds the pointer
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 1'b0, 1'b0);
      chk_wr("R9 no strobes", -1);
      cyc(1'b0, 1'b0, 1'b0);
      chk("R9 no conversion", int'(conv_start), 0);
    end
    cyc(1'b1, 1'b0, 1'b0);
    chk_wr("R9 pointer held at 0", 0);
    cyc(1'b1, 1'b0, 1'b0);
    chk_wr("R2 next cell", 1);
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R4 stop address 2", int'(stop_addr), 2);
    // R8: trig high while converting leaves strobes off
    cyc(1'b1, 1'b0, 1'b0);
    chk_wr("R8 no strobes in convert", -1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule